// File: doc/BRIEF.md
# Per-Slave Interrupt Status Aggregator

This block gathers interrupt events raised by up to sixteen slaves on a serial power-management bus and turns them into a single level interrupt for the host. A front end that decodes interrupt requests from the serial line presents each event as a one-cycle strobe. The strobe carries the slave ID and an 8-bit event vector. The aggregator stores the vector in an 8-bit lane that belongs to that slave. Four slaves share each 32-bit status register, and the host clears lanes by writing ones over them.

The host reads and writes through a simple register port. A write takes effect on the clock edge. A read is combinational on the address. A 16-bit enable register chooses which slaves may drive the interrupt output. Status bits stay visible even when a slave is masked. A read-only summary register shows, with one bit per slave, which lanes hold anything. Interrupt service is a simple loop: read the summary, read the status word for the flagged slave, then write ones back to that lane.

Top module: `slv_irq_agg`

## Requirements
- R1: After reset, every status lane, the enable register and the summary read zero, and `irq_out` is low.
- R2: An event strobe ORs `evt_vec` into the lane of slave `evt_sid` on the clock edge where `evt_valid` is high. Slave n lives in the status register at byte address 0x20 + 4*(n/4), bits [(n%4)*8+7 : (n%4)*8].
- R3: A write to a status register clears exactly the bits written as 1. Bits written as 0 keep their value, so writing 0xFF over a lane empties it and leaves its neighbours alone.
- R4: Writing 0xFFFFFFFF to all four status registers (0x20, 0x24, 0x28, 0x2C) clears every pending event.
- R5: When an event sets a bit in the same cycle that a register write clears it, the bit ends up set.
- R6: The enable register at 0x30 holds bit n for slave n in bits [15:0]. Bits [31:16] read as zero and ignore writes.
- R7: `irq_out` is high, as a level, whenever at least one slave has its enable bit set and a nonzero lane. It stays high until the lane is cleared or the slave is disabled.
- R8: A disabled slave's events are still stored and readable in its status lane and in the summary, but they do not raise `irq_out`.
- R9: The summary register at 0x34 shows bit n set exactly when slave n's lane is nonzero. Writes to 0x34 have no effect.
- R10: Reads from an address with no register (for example 0x40) return zero. Writes to such an address change no state.
- R11: A write to one status register does not change the lanes held in the other status registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | 1 | Event strobe, one cycle per event |
| evt_sid | input | 4 | Slave ID of the event |
| evt_vec | input | 8 | Event bits ORed into that slave's lane |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 8 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_out | output | 1 | Level interrupt to the host |

## Verification
The bench goes after the lane arithmetic at its edges. It uses slave 0, slave 3, slave 5 and slave 15, so a lane shift that is off by one slave or one register places bits in the wrong byte or word. Partial clear masks check that only the addressed bits and the addressed register are affected. A design that cleared a whole register, or a whole lane on any write, would lose neighbour events. A set and a clear aimed at the same bit in the same cycle expose a design that lets the clear win, which drops a fresh event. Masked slaves, writes to the summary and writes to an unmapped address check that `irq_out` follows only enabled lanes and that the read-only and empty addresses cannot disturb the enable register or the status lanes.

// File: rtl/slv_irq_pkg.sv
package slv_irq_pkg;
  // width of one slave's status lane
  localparam int LANE_W     = 8;
  // register layout
  localparam int STAT_BASE  = 'h20;
  localparam int REG_STRIDE = 4;
  localparam int EN_OFS     = 'h30;
  localparam int SUM_OFS    = 'h34;

  // byte address of status register r
  function automatic int stat_addr(input int r);
    return STAT_BASE + r * REG_STRIDE;
  endfunction

  // least significant bit of slave sid within the flattened status vector;
  // lanes pack four per 32-bit word, so word*32 + (sid%4)*8 equals sid*8
  function automatic int lane_lsb(input int sid);
    return sid * LANE_W;
  endfunction
endpackage

// File: rtl/irq_lane.sv
module irq_lane #(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANE_W-1:0] set_vec,
  input  logic [LANE_W-1:0] clr_vec,
  output logic [LANE_W-1:0] lane_q,
  output logic              nz
);
  // clear first, then OR in the new events, so a set beats a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lane_q <= '0;
    else        lane_q <= (lane_q & ~clr_vec) | set_vec;
  end

  assign nz = |lane_q;
endmodule

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
  import slv_irq_pkg::*;
#(
  parameter int NUM_REG = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input  logic                      reg_wr,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [DATA_W-1:0]         reg_wdata,
  output logic [NUM_REG*DATA_W-1:0] clr_mask,
  output logic                      en_wr
);
  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    logic hit;
    assign hit = reg_wr && (reg_addr == ADDR_W'(stat_addr(r)));
    assign clr_mask[r*DATA_W +: DATA_W] = hit ? reg_wdata : '0;
  end

  assign en_wr = reg_wr && (reg_addr == ADDR_W'(EN_OFS));
endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
  import slv_irq_pkg::*;
#(
  parameter int NUM_REG = 4,
  parameter int NUM_SLV = 16,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [NUM_REG*DATA_W-1:0] status_flat,
  input  logic [NUM_SLV-1:0]        en_q,
  input  logic [NUM_SLV-1:0]        lane_nz,
  output logic [DATA_W-1:0]         reg_rdata
);
  always_comb begin
    reg_rdata = '0;
    for (int r = 0; r < NUM_REG; r++) begin
      if (reg_addr == ADDR_W'(stat_addr(r))) reg_rdata = status_flat[r*DATA_W +: DATA_W];
    end
    if (reg_addr == ADDR_W'(EN_OFS))  reg_rdata = DATA_W'(en_q);
    if (reg_addr == ADDR_W'(SUM_OFS)) reg_rdata = DATA_W'(lane_nz);
  end
endmodule

// File: rtl/slv_irq_agg.sv
module slv_irq_agg
  import slv_irq_pkg::*;
#(
  parameter int NUM_SLV = 16,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int SID_W   = $clog2(NUM_SLV)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [SID_W-1:0]  evt_sid,
  input  logic [LANE_W-1:0] evt_vec,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_out
);
  localparam int LANES_PER_REG = DATA_W / LANE_W;
  localparam int NUM_REG       = NUM_SLV / LANES_PER_REG;
  localparam int FLAT_W        = NUM_SLV * LANE_W;

  // named internal events, observed by the checker
  logic [FLAT_W-1:0]  status_flat;
  logic [FLAT_W-1:0]  set_mask_w;
  logic [FLAT_W-1:0]  clr_mask_w;
  logic [NUM_SLV-1:0] lane_nz_w;
  logic [NUM_SLV-1:0] en_q;
  logic               en_wr;

  irq_wr_decode #(
    .NUM_REG (NUM_REG),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
  ) u_wr (
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .clr_mask  (clr_mask_w),
    .en_wr     (en_wr)
  );

  for (genvar n = 0; n < NUM_SLV; n++) begin : g_slv
    assign set_mask_w[lane_lsb(n) +: LANE_W] =
      (evt_valid && (evt_sid == SID_W'(n))) ? evt_vec : '0;

    irq_lane #(.LANE_W(LANE_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_mask_w[lane_lsb(n) +: LANE_W]),
      .clr_vec (clr_mask_w[lane_lsb(n) +: LANE_W]),
      .lane_q  (status_flat[lane_lsb(n) +: LANE_W]),
      .nz      (lane_nz_w[n])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= reg_wdata[NUM_SLV-1:0];
  end

  irq_rd_mux #(
    .NUM_REG (NUM_REG),
    .NUM_SLV (NUM_SLV),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
  ) u_rd (
    .reg_addr    (reg_addr),
    .status_flat (status_flat),
    .en_q        (en_q),
    .lane_nz     (lane_nz_w),
    .reg_rdata   (reg_rdata)
  );

  assign irq_out = |(lane_nz_w & en_q);
endmodule

// File: rtl/slv_irq_agg_chk.sv
module slv_irq_agg_chk #(
  parameter int NUM_SLV = 16,
  parameter int LANE_W  = 8,
  parameter int SID_W   = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      evt_valid,
  input logic [SID_W-1:0]          evt_sid,
  input logic [LANE_W-1:0]         evt_vec,
  input logic                      irq_out,
  input logic [NUM_SLV*LANE_W-1:0] status_flat,
  input logic [NUM_SLV*LANE_W-1:0] set_mask_w,
  input logic [NUM_SLV*LANE_W-1:0] clr_mask_w,
  input logic [NUM_SLV-1:0]        en_q,
  input logic [NUM_SLV-1:0]        lane_nz_w
);
  logic              ev_v_q;
  logic [SID_W-1:0]  ev_sid_q;
  logic [LANE_W-1:0] ev_vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_v_q   <= 1'b0;
      ev_sid_q <= '0;
      ev_vec_q <= '0;
    end else begin
      ev_v_q   <= evt_valid;
      ev_sid_q <= evt_sid;
      ev_vec_q <= evt_vec;
    end
  end

  // R2 and R5: an event's bits are present one edge later, whatever was written
  a_r5_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ev_v_q |-> ((status_flat[ev_sid_q*LANE_W +: LANE_W] & ev_vec_q) == ev_vec_q));

  // R2: a bit rises only where an event placed it
  a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    ((~$past(status_flat) & status_flat & ~$past(set_mask_w)) == '0));

  // R3: a bit falls only where a register write cleared it
  a_r3_clear_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status_flat) & ~status_flat & ~$past(clr_mask_w)) == '0));

  // R8: with every slave masked the output stays low
  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_out);

  // R7: no pending lane means no interrupt
  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (status_flat == '0) |-> !irq_out);

  // R7: an enabled pending lane keeps the level up
  a_r7_level_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((lane_nz_w & en_q) != '0) |-> irq_out);
endmodule

bind slv_irq_agg slv_irq_agg_chk #(
  .NUM_SLV (NUM_SLV),
  .LANE_W  (slv_irq_pkg::LANE_W),
  .SID_W   (SID_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_valid   (evt_valid),
  .evt_sid     (evt_sid),
  .evt_vec     (evt_vec),
  .irq_out     (irq_out),
  .status_flat (status_flat),
  .set_mask_w  (set_mask_w),
  .clr_mask_w  (clr_mask_w),
  .en_q        (en_q),
  .lane_nz_w   (lane_nz_w)
);

// File: tb/tb_slv_irq_agg.sv
module tb_slv_irq_agg;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [3:0]  evt_sid = '0;
  logic [7:0]  evt_vec = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  slv_irq_agg dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_sid   (evt_sid),
    .evt_vec   (evt_vec),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out)
  );

  localparam logic [1:0] OP_EV = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;   // event: sid in [11:8], vector in [7:0]
    logic [31:0] exp;
    logic        irq;
    logic [3:0]  req;
  } step_t;

  localparam int NSTEP = 34;
  localparam step_t TBL [NSTEP] = '{
    '{OP_RD, 8'h20, 32'h0,        32'h0,        1'b0, 4'd1},  // R1
    '{OP_RD, 8'h30, 32'h0,        32'h0,        1'b0, 4'd1},  // R1
    '{OP_RD, 8'h34, 32'h0,        32'h0,        1'b0, 4'd1},  // R1
    '{OP_EV, 8'h00, 32'h0581,     32'h0,        1'b0, 4'd2},  // R2 slave 5
    '{OP_RD, 8'h24, 32'h0,        32'h00008100, 1'b0, 4'd2},  // R2
    '{OP_RD, 8'h34, 32'h0,        32'h00000020, 1'b0, 4'd9},  // R9
    '{OP_WR, 8'h30, 32'hFFFF0020, 32'h0,        1'b0, 4'd6},  // R6
    '{OP_RD, 8'h30, 32'h0,        32'h00000020, 1'b1, 4'd6},  // R6 R7
    '{OP_EV, 8'h00, 32'h0F3C,     32'h0,        1'b0, 4'd2},  // R2 slave 15
    '{OP_RD, 8'h2C, 32'h0,        32'h3C000000, 1'b1, 4'd2},  // R2
    '{OP_WR, 8'h24, 32'h00000100, 32'h0,        1'b0, 4'd3},  // R3 partial
    '{OP_RD, 8'h24, 32'h0,        32'h00008000, 1'b1, 4'd3},  // R3
    '{OP_WR, 8'h2C, 32'h00FFFFFF, 32'h0,        1'b0, 4'd3},  // R3 other lanes
    '{OP_RD, 8'h2C, 32'h0,        32'h3C000000, 1'b1, 4'd3},  // R3
    '{OP_WR, 8'h24, 32'h0000FF00, 32'h0,        1'b0, 4'd3},  // R3 whole lane
    '{OP_RD, 8'h24, 32'h0,        32'h0,        1'b0, 4'd7},  // R7 drops
    '{OP_RD, 8'h34, 32'h0,        32'h00008000, 1'b0, 4'd8},  // R8 masked
    '{OP_WR, 8'h34, 32'hFFFFFFFF, 32'h0,        1'b0, 4'd9},  // R9 read-only
    '{OP_RD, 8'h34, 32'h0,        32'h00008000, 1'b0, 4'd9},  // R9
    '{OP_WR, 8'h40, 32'hFFFFFFFF, 32'h0,        1'b0, 4'd10}, // R10
    '{OP_RD, 8'h40, 32'h0,        32'h0,        1'b0, 4'd10}, // R10
    '{OP_RD, 8'h2C, 32'h0,        32'h3C000000, 1'b0, 4'd10}, // R10
    '{OP_RD, 8'h30, 32'h0,        32'h00000020, 1'b0, 4'd10}, // R10
    '{OP_EV, 8'h00, 32'h0001,     32'h0,        1'b0, 4'd2},  // R2 slave 0
    '{OP_EV, 8'h00, 32'h0380,     32'h0,        1'b0, 4'd2},  // R2 slave 3
    '{OP_RD, 8'h20, 32'h0,        32'h80000001, 1'b0, 4'd2},  // R2
    '{OP_WR, 8'h28, 32'hFFFFFFFF, 32'h0,        1'b0, 4'd11}, // R11
    '{OP_RD, 8'h20, 32'h0,        32'h80000001, 1'b0, 4'd11}, // R11
    '{OP_WR, 8'h20, 32'hFFFFFFFF, 32'h0,        1'b0, 4'd4},  // R4
    '{OP_WR, 8'h24, 32'hFFFFFFFF, 32'h0,        1'b0, 4'd4},  // R4
    '{OP_WR, 8'h28, 32'hFFFFFFFF, 32'h0,        1'b0, 4'd4},  // R4
    '{OP_WR, 8'h2C, 32'hFFFFFFFF, 32'h0,        1'b0, 4'd4},  // R4
    '{OP_RD, 8'h34, 32'h0,        32'h0,        1'b0, 4'd4},  // R4
    '{OP_RD, 8'h2C, 32'h0,        32'h0,        1'b0, 4'd4}   // R4
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one operation at a falling edge; it is applied on the next rising edge
  task automatic do_op(input logic [1:0] op, input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    evt_valid = (op == OP_EV);
    evt_sid   = data[11:8];
    evt_vec   = data[7:0];
    reg_wr    = (op == OP_WR);
    reg_addr  = addr;
    reg_wdata = data;
  endtask

  task automatic idle();
    @(negedge clk);
    evt_valid = 1'b0;
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] addr, input logic [31:0] exp, input logic exp_irq,
                    input string req);
    idle();
    reg_addr = addr;
    #1;
    check(reg_rdata, exp, req);
    check({31'b0, irq_out}, {31'b0, exp_irq}, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NSTEP; i++) begin
      if (TBL[i].op == OP_RD) begin
        rd(TBL[i].addr, TBL[i].exp, TBL[i].irq, $sformatf("R%0d step %0d", TBL[i].req, i));
      end else begin
        do_op(TBL[i].op, TBL[i].addr, TBL[i].data);
      end
    end

    // R5: event on slave 5 bit 0 while the whole register 0x24 is cleared
    do_op(OP_EV, 8'h00, 32'h0580);
    do_op(OP_EV, 8'h00, 32'h0402);
    rd(8'h24, 32'h00008002, 1'b1, "R5 preload");
    @(negedge clk);
    evt_valid = 1'b1; evt_sid = 4'd5; evt_vec = 8'h01;
    reg_wr = 1'b1; reg_addr = 8'h24; reg_wdata = 32'hFFFFFFFF;
    rd(8'h24, 32'h00000100, 1'b1, "R5 set wins");

    // R7: level holds while the lane stays pending
    for (int k = 0; k < 5; k++) begin
      rd(8'h24, 32'h00000100, 1'b1, "R7 hold");
    end

    // R8: disabling the slave drops the output but keeps the status
    do_op(OP_WR, 8'h30, 32'h0);
    rd(8'h24, 32'h00000100, 1'b0, "R8 masked status");
    rd(8'h34, 32'h00000020, 1'b0, "R8 summary");

    // R1: reset in the middle of activity
    do_op(OP_WR, 8'h30, 32'h0000FFFF);
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(8'h24, 32'h0, 1'b0, "R1 status after reset");
    rd(8'h30, 32'h0, 1'b0, "R1 enable after reset");
    rd(8'h34, 32'h0, 1'b0, "R1 summary after reset");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule